// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Lookup

This block is the read side of a small two-way set-associative cache. A request carries a byte address. The address is split into three fields: a word select, a set index, and a tag. Every set stores one prediction bit, which names the way that is expected to hold the next access. In the cycle after a request is accepted, the data multiplexer is steered by that bit straight away. The tag compare resolves in parallel, and its result only decides whether the word that was already steered out counts as valid.

When the predicted way holds the tag, the word is returned one cycle after the request. When only the other way holds it, the block raises a busy flag for one cycle and returns the other way's word one cycle later. At the same time it retrains the set's prediction bit to point at that way. When neither way holds the tag, the block flags a miss and leaves the prediction alone. A fill port installs a whole line into a chosen way and points the prediction at that way. The surrounding logic decides when to refill after a miss and which way to replace.

Top module: `wp_cache_lookup`

## Requirements
- R1: After a synchronous active-low reset, busy, rsp_valid and rsp_miss are low, and every lookup misses until a fill has been made.
- R2: The set index is addr[9:4] (block address modulo 64), the tag is addr[31:10], and addr[3:2] selects word k of the line. Word k occupies fill_line[32k+31:32k]. addr[1:0] must be zero. The same tag in a different set does not hit.
- R3: When the predicted way hits, rsp_valid is high and rsp_data holds the word in the cycle after the request is accepted, with busy low.
- R4: When only the non-predicted way hits, busy is high and rsp_valid is low in the cycle after the request. In the following cycle, rsp_valid is high with that way's word.
- R5: After an R4 access, the set's prediction points at the way that hit, so the next hit in that way completes as in R3.
- R6: When neither way hits, rsp_miss is high and rsp_valid is low in the cycle after the request, and the set's prediction is unchanged.
- R7: A fill (fill_en high for one cycle) writes the tag and the line into way fill_way of set fill_set and marks it valid. It sets that set's prediction to fill_way and replaces whatever that way held before. If a fill and a retrain hit the same set on the same edge, the fill wins.
- R8: A request that is presented while busy is high is ignored and produces no response.
- R9: Requests may be accepted on consecutive cycles while no misprediction occurs, and each produces one response in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request, accepted when busy is low |
| req_addr | input | 32 | Word-aligned byte address of the read |
| busy | output | 1 | Misprediction cycle; new requests are not accepted |
| rsp_valid | output | 1 | rsp_data holds the requested word |
| rsp_miss | output | 1 | Neither way holds the requested line |
| rsp_data | output | 32 | Returned word |
| fill_en | input | 1 | Install a line this cycle |
| fill_way | input | 1 | Way to be written by the fill |
| fill_set | input | 6 | Set index of the fill |
| fill_tag | input | 22 | Tag of the installed line |
| fill_line | input | 128 | Line data, word k at bits [32k+31:32k] |

## Verification
A stale or wrong prediction bit never corrupts data. It only shows up as timing: a hit that should take one cycle raises busy and answers a cycle late, or a hit that should stall answers at once. The bench therefore checks the latency class of every response as well as its value. It reads the same set again right after a retrain, a miss or a fill, so a bad prediction update is exposed on the very next access to that set. A wrong valid bit or tag shows up as a miss where a hit was due, or the reverse, one cycle after the request. A wrong word select or set index shows up as a data mismatch in that same cycle.

// File: rtl/cwp_pkg.sv
// Shared types for the way-predicted lookup.
// Assumes a fixed associativity of two; the way number is a single bit.
package cwp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no lookup in flight
        ST_LOOK = 2'd1,   // tag compare against the predicted way
        ST_ALT  = 2'd2    // returning the other way after a mispredict
    } cwp_state_e;
endpackage

// File: rtl/cwp_way_bank.sv
// One way of the cache: valid bits, tags and line data per set.
// Read is combinational on rd_idx and compares against rd_tag, so a hit
// is known in the same cycle as the index. Tags and data are not reset;
// only the valid bits are.
module cwp_way_bank #(
    parameter int SETS   = 64,
    parameter int TAG_W  = 22,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit,
    output logic [LINE_W-1:0] rd_line
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    // Valid bits: cleared on reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and line storage written by a fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    // Lookup: hit on valid entry with matching tag; line steered regardless.
    always_comb begin
        hit     = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
        rd_line = line_mem[rd_idx];
    end

    // R7: a written entry reads back valid on the next cycle.
    assert_fill_marks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/cwp_pred_table.sv
// Per-set prediction bits naming the way expected to hit next.
// Assumes at most one retrain and one fill per cycle; when both address
// the same set the fill value is kept.
module cwp_pred_table #(
    parameter int SETS = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way
);
    logic [SETS-1:0] pred_q;

    // Prediction update: reset to way 0, retrain on mispredict, fill last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else begin
            if (upd_en) begin
                pred_q[upd_idx] <= upd_way;
            end
            if (fill_en) begin
                pred_q[fill_idx] <= fill_way;
            end
        end
    end

    // Prediction read as soon as the index is registered.
    assign rd_way = pred_q[rd_idx];

    // R6: without a retrain or fill, no prediction changes.
    assert_pred_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !fill_en) |=> $stable(pred_q));

    // R7: a fill leaves the filled way as the prediction, even against a retrain.
    assert_fill_sets_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (pred_q[$past(fill_idx)] == $past(fill_way)));
endmodule

// File: rtl/cwp_lookup_ctrl.sv
// Request register and lookup sequencing for the two-way cache.
// Registers the address fields of an accepted request, steers the data
// multiplexer from the prediction, resolves hit/mispredict/miss and
// stalls one cycle to return the other way. Assumes word-aligned requests.
module cwp_lookup_ctrl
    import cwp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 6,
    parameter int TAG_W    = 22,
    parameter int WSEL_W   = 2,
    parameter int BYTE_OFF = 2,
    localparam int OFF_W   = BYTE_OFF + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        way_hit,
    input  logic              pred_way,
    output logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    output logic [WSEL_W-1:0] look_wsel,
    output logic              sel_way,
    output logic              upd_en,
    output logic              upd_way,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_miss
);
    cwp_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WSEL_W-1:0] wsel_q;
    logic              alt_q;
    logic              accept;
    logic              pred_hit, other_hit;

    // Outcome decode for the lookup cycle.
    always_comb begin
        pred_hit  = way_hit[pred_way];
        other_hit = way_hit[~pred_way];
        busy      = (state_q == ST_LOOK) && !pred_hit && other_hit;
        rsp_valid = ((state_q == ST_LOOK) && pred_hit) || (state_q == ST_ALT);
        rsp_miss  = (state_q == ST_LOOK) && (way_hit == 2'b00);
        sel_way   = (state_q == ST_ALT) ? alt_q : pred_way;
        accept    = req_valid && !busy;
        upd_en    = busy;
        upd_way   = ~pred_way;
    end

    // Next state: a new request wins, a mispredict goes to the extra cycle.
    always_comb begin
        if (accept) begin
            state_d = ST_LOOK;
        end else if (busy) begin
            state_d = ST_ALT;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // State, request fields and the way to return after a mispredict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            tag_q   <= '0;
            wsel_q  <= '0;
            alt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q  <= req_addr[OFF_W +: IDX_W];
                tag_q  <= req_addr[ADDR_W-1 -: TAG_W];
                wsel_q <= req_addr[BYTE_OFF +: WSEL_W];
            end
            if (busy) begin
                alt_q <= ~pred_way;
            end
        end
    end

    assign look_idx  = idx_q;
    assign look_tag  = tag_q;
    assign look_wsel = wsel_q;

    // R2: requests carry word-aligned addresses.
    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[BYTE_OFF-1:0] == '0));

    // R3: every accepted request shows an outcome on the next cycle.
    assert_outcome_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rsp_valid || rsp_miss || busy));

    // R6: a miss and a valid word never coincide.
    assert_miss_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_miss));

    // R4: the stall cycle is followed by the data cycle, never a second stall.
    assert_alt_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rsp_valid && !busy));

    // R8: a request seen during the stall does not start a lookup.
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_q == ST_ALT));
endmodule

// File: rtl/wp_cache_lookup.sv
// Top of the way-predicted two-way read lookup.
// Builds two way banks, the per-set prediction table and the controller,
// and drives the returned word through a multiplexer steered by the
// prediction (or by the retained other way during the extra cycle).
// Assumes fills are not issued to a set while a lookup to it is in flight.
module wp_cache_lookup
    import cwp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 16,
    localparam int BYTE_OFF  = $clog2(DATA_W / 8),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WORDS     = LINE_W / DATA_W,
    localparam int WSEL_W    = $clog2(WORDS),
    localparam int IDX_W     = $clog2(SETS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [WSEL_W-1:0] look_wsel;
    logic [1:0]        way_hit;
    logic [LINE_W-1:0] way_line [2];
    logic [LINE_W-1:0] sel_line;
    logic              pred_way, sel_way, upd_en, upd_way;

    // One bank per way, written only when the fill targets it.
    for (genvar w = 0; w < 2; w++) begin : g_way
        cwp_way_bank #(
            .SETS   (SETS),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (fill_en && (fill_way == 1'(w))),
            .wr_idx  (fill_set),
            .wr_tag  (fill_tag),
            .wr_line (fill_line),
            .rd_idx  (look_idx),
            .rd_tag  (look_tag),
            .hit     (way_hit[w]),
            .rd_line (way_line[w])
        );
    end

    cwp_pred_table #(
        .SETS (SETS)
    ) pred_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_way   (pred_way),
        .upd_en   (upd_en),
        .upd_idx  (look_idx),
        .upd_way  (upd_way),
        .fill_en  (fill_en),
        .fill_idx (fill_set),
        .fill_way (fill_way)
    );

    cwp_lookup_ctrl #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .TAG_W    (TAG_W),
        .WSEL_W   (WSEL_W),
        .BYTE_OFF (BYTE_OFF)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .way_hit   (way_hit),
        .pred_way  (pred_way),
        .look_idx  (look_idx),
        .look_tag  (look_tag),
        .look_wsel (look_wsel),
        .sel_way   (sel_way),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_miss  (rsp_miss)
    );

    // Output word: way chosen ahead of the compare, then word within line.
    always_comb begin
        sel_line = way_line[sel_way];
        rsp_data = sel_line[look_wsel * DATA_W +: DATA_W];
    end
endmodule

// File: tb/wp_cache_lookup_tb_top.sv
`timescale 1ns/1ps
module wp_cache_lookup_tb_top;
    localparam int K_FAST = 0;
    localparam int K_ALT  = 1;
    localparam int K_MISS = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         busy, rsp_valid, rsp_miss;
    logic [31:0]  rsp_data;
    logic         fill_en = 1'b0;
    logic         fill_way = 1'b0;
    logic [5:0]   fill_set = '0;
    logic [21:0]  fill_tag = '0;
    logic [127:0] fill_line = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int          exp_kind_q[$];
    logic [31:0] exp_data_q[$];
    string       exp_req_q[$];
    bit          alt_pending = 1'b0;
    logic [31:0] alt_data;
    string       alt_req;

    always #2 clk = ~clk;

    wp_cache_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_data(rsp_data),
        .fill_en(fill_en), .fill_way(fill_way), .fill_set(fill_set),
        .fill_tag(fill_tag), .fill_line(fill_line)
    );

    localparam logic [21:0] T1 = 22'h0_00A1;
    localparam logic [21:0] T2 = 22'h0_01B2;
    localparam logic [21:0] T3 = 22'h0_02C3;
    localparam logic [21:0] T4 = 22'h0_03D4;
    localparam logic [21:0] T5 = 22'h0_04E5;
    localparam logic [21:0] TA = 22'h1_00F6;
    localparam logic [21:0] TB = 22'h2_0117;

    function automatic logic [31:0] word_of(input logic [21:0] tag, input logic [5:0] set,
                                            input int k, input logic way);
        return {tag[11:0], set, 2'(k), way, 11'h5A3};
    endfunction

    function automatic logic [127:0] line_of(input logic [21:0] tag, input logic [5:0] set,
                                             input logic way);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[32*k +: 32] = word_of(tag, set, k, way);
        return l;
    endfunction

    function automatic logic [31:0] addr_of(input logic [21:0] tag, input logic [5:0] set,
                                            input int k);
        return {tag, set, 2'(k), 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic do_fill(input logic way, input logic [21:0] tag, input logic [5:0] set);
        @(negedge clk);
        fill_en = 1'b1; fill_way = way; fill_set = set; fill_tag = tag;
        fill_line = line_of(tag, set, way);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic issue(input logic [21:0] tag, input logic [5:0] set, input int k,
                         input int kind, input logic [31:0] d, input string req);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr_of(tag, set, k);
        exp_kind_q.push_back(kind);
        exp_data_q.push_back(d);
        exp_req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items as responses appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (alt_pending) begin
                alt_pending = 1'b0;
                check(rsp_valid && !busy, alt_req, "late valid after stall",
                      {31'd0, rsp_valid}, 32'd1);
                check(rsp_data == alt_data, alt_req, "other-way data", rsp_data, alt_data);
            end else if (busy || rsp_valid || rsp_miss) begin
                if (exp_kind_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected response",
                          {29'd0, busy, rsp_valid, rsp_miss}, 32'd0);
                end else begin
                    int kind;
                    logic [31:0] d;
                    string req;
                    kind = exp_kind_q.pop_front();
                    d    = exp_data_q.pop_front();
                    req  = exp_req_q.pop_front();
                    if (kind == K_ALT) begin
                        check(busy && !rsp_valid && !rsp_miss, req, "stall cycle",
                              {29'd0, busy, rsp_valid, rsp_miss}, 32'd4);
                        if (busy) begin
                            alt_pending = 1'b1;
                            alt_data = d;
                            alt_req = req;
                        end
                    end else if (kind == K_FAST) begin
                        check(rsp_valid && !busy && !rsp_miss, req, "one-cycle hit",
                              {29'd0, busy, rsp_valid, rsp_miss}, 32'd2);
                        check(rsp_data == d, req, "hit data", rsp_data, d);
                    end else begin
                        check(rsp_miss && !rsp_valid && !busy, req, "miss flag",
                              {29'd0, busy, rsp_valid, rsp_miss}, 32'd1);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        check(!busy && !rsp_valid && !rsp_miss, "R1", "outputs in reset",
              {29'd0, busy, rsp_valid, rsp_miss}, 32'd0);
        rst_n = 1'b1;

        issue(T1, 6'd5, 0, K_MISS, '0, "R1");
        idle(3);

        do_fill(1'b0, T1, 6'd5);
        do_fill(1'b1, T2, 6'd5);                                         // prediction: way 1
        issue(T2, 6'd5, 2, K_FAST, word_of(T2, 6'd5, 2, 1'b1), "R3");
        issue(T1, 6'd5, 1, K_ALT,  word_of(T1, 6'd5, 1, 1'b0), "R4");    // retrain to way 0
        issue(T1, 6'd5, 3, K_FAST, word_of(T1, 6'd5, 3, 1'b0), "R5");
        issue(T2, 6'd5, 0, K_ALT,  word_of(T2, 6'd5, 0, 1'b1), "R4");    // retrain to way 1
        issue(T3, 6'd5, 0, K_MISS, '0, "R6");
        issue(T2, 6'd5, 3, K_FAST, word_of(T2, 6'd5, 3, 1'b1), "R6");    // unchanged by miss
        issue(T1, 6'd6, 0, K_MISS, '0, "R2");                            // same tag, other set
        idle(3);

        do_fill(1'b1, T5, 6'd5);                                         // replaces T2
        issue(T2, 6'd5, 1, K_MISS, '0, "R7");
        issue(T5, 6'd5, 1, K_FAST, word_of(T5, 6'd5, 1, 1'b1), "R7");
        issue(T1, 6'd5, 2, K_ALT,  word_of(T1, 6'd5, 2, 1'b0), "R7");
        idle(3);

        do_fill(1'b0, T1, 6'd7);
        do_fill(1'b1, T4, 6'd8);
        for (int k = 0; k < 4; k++)
            issue(T1, 6'd7, k, K_FAST, word_of(T1, 6'd7, k, 1'b0), "R9");
        issue(T4, 6'd8, 0, K_FAST, word_of(T4, 6'd8, 0, 1'b1), "R9");
        issue(T4, 6'd8, 3, K_FAST, word_of(T4, 6'd8, 3, 1'b1), "R2");
        idle(3);

        do_fill(1'b0, TA, 6'd9);
        do_fill(1'b1, TB, 6'd9);                                         // prediction: way 1
        issue(TA, 6'd9, 2, K_ALT, word_of(TA, 6'd9, 2, 1'b0), "R8");
        @(negedge clk);                                                  // stall cycle
        req_valid = 1'b1;
        req_addr  = addr_of(T1, 6'd7, 1);                                // must be dropped
        @(negedge clk);
        req_valid = 1'b0;
        idle(3);
        issue(TA, 6'd9, 0, K_FAST, word_of(TA, 6'd9, 0, 1'b0), "R5");
        idle(4);

        // R8/R9: every expected response arrived, nothing left over
        check(exp_kind_q.size() == 0 && !alt_pending, "R9", "responses outstanding",
              32'(exp_kind_q.size()), 32'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule